// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

A memory-mapped watchdog that counts down from a programmed reload value and signals a timeout when the count is used up. Software keeps the system running by writing a fixed 16-bit key to a dedicated restart register before the count runs out. Any other value written there leaves the count alone. A control register holds three separate switches. One gates counting. One lets a timeout drive a system reset pulse. One picks the count rate: a slow tick made by an internal prescaler (1 MHz when the prescaler divides the bus clock down to it) or the bus clock itself.

The register bus is a single-cycle write port with a combinational read mux. The expected bring-up order is: clear control, program the reload value, write the key, then enable with reset and the slow tick selected. At a 1 MHz tick, reload 0x00500000 is roughly 5 s and 0x06000000 roughly 100 s.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the counter, reload and control registers read as 0, and the timeout and system reset outputs are low.
- R2: Word offset 0x04 (byte address bits [3:2] = 1) holds the reload value. A write stores it and a read returns it.
- R3: A control write that sets bit 0 while bit 0 was clear loads the counter from the reload value on that write edge. While bit 0 is set and bit 4 is clear, the counter then drops by one on every clock edge.
- R4: A write of exactly 0x00004755 to the restart register at offset 0x08 loads the reload value into the counter on that edge. A write of any other value to offset 0x08 leaves the count running unchanged.
- R5: When the counter is enabled, a count tick that finds it at 0 raises timeout_o for exactly one cycle, in the cycle after that edge. If control bit 1 is clear, the counter reloads from the reload value on that same edge and keeps counting.
- R6: If control bit 1 is set at that timeout, sys_rst_o goes high in the same cycle as timeout_o and stays high for RST_PULSE_LEN cycles. The counter then holds at 0 until a restart key is written or the block is re-enabled.
- R7: With control bit 4 set, the counter drops by one only once every PRESCALE_DIV clocks. The prescaler phase is cleared whenever the counter is loaded, so the first decrement comes PRESCALE_DIV clocks after the load.
- R8: Writing 0 to control freezes the counter at its current value, and no timeout or reset follows.
- R9: Writes to offset 0x00 are ignored. Reads of offset 0x08 return 0.
- R10: Control bits other than 0, 1 and 4 are stored and read back at offset 0x0C, but they have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr_i | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| timeout_o | output | 1 | One-cycle timeout flag |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the block with PRESCALE_DIV = 4 and RST_PULSE_LEN = 3. The short divide puts several slow-tick decrements and a full prescaled timeout-and-reload cycle within a few dozen clocks. The three-cycle pulse lets the bench see both edges of the reset and check that the counter stays halted afterwards. Reload values of 10 and 2 place each timeout at a cycle that can be predicted exactly from the load edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_RESTART = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_RST  = 1;
  localparam int unsigned CTRL_SLOW = 4;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              load_o
);
  reg_sel_e          sel;
  logic [CNT_W-1:0]  reload_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              key_hit, en_rise;

  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign key_hit = we_i && (sel == SEL_RESTART) && (wdata_i == RESTART_KEY);
  assign en_rise = we_i && (sel == SEL_CTRL) && wdata_i[CTRL_EN] && !ctrl_q[CTRL_EN];
  assign load_o  = key_hit || en_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      ctrl_q   <= '0;
    end else if (we_i) begin
      if (sel == SEL_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
      if (sel == SEL_CTRL)   ctrl_q   <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_COUNT:   rdata_o[CNT_W-1:0] = cnt_i;
      SEL_RELOAD:  rdata_o[CNT_W-1:0] = reload_q;
      SEL_RESTART: rdata_o = '0;
      SEL_CTRL:    rdata_o = ctrl_q;
      default:     rdata_o = '0;
    endcase
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (clr_i)               pre_q <= '0;
    else if (run_i) pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  assign tick_o = run_i && (pre_q == LAST);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned CNT_W         = 32,
  parameter int unsigned RST_PULSE_LEN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic             rst_en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             timeout_o,
  output logic             sys_rst_o
);
  localparam int unsigned PW = $clog2(RST_PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             halted_q, to_q;
  logic [PW-1:0]    pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      halted_q <= 1'b0;
      to_q     <= 1'b0;
      pulse_q  <= '0;
    end else begin
      to_q <= 1'b0;
      if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
      if (load_i) begin
        cnt_q    <= reload_i;
        halted_q <= 1'b0;
      end else if (running_o && tick_i) begin
        if (cnt_q == '0) begin
          to_q <= 1'b1;
          if (rst_en_i) begin
            halted_q <= 1'b1;
            pulse_q  <= PW'(RST_PULSE_LEN);
          end else begin
            cnt_q <= reload_i;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign running_o = en_i && !halted_q;
  assign cnt_o     = cnt_q;
  assign timeout_o = to_q;
  assign sys_rst_o = (pulse_q != '0);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W         = 32,
  parameter int unsigned PRESCALE_DIV  = 125,
  parameter int unsigned RST_PULSE_LEN = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        timeout_o,
  output logic        sys_rst_o
);
  logic [CNT_W-1:0]  cnt_w, reload_w;
  logic [DATA_W-1:0] ctrl_w;
  logic              load_w, running_w, slow_tick_w, tick_w;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .cnt_i    (cnt_w),
    .rdata_o  (bus_rdata_o),
    .reload_o (reload_w),
    .ctrl_o   (ctrl_w),
    .load_o   (load_w)
  );

  wdt_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_w),
    .run_i  (running_w),
    .tick_o (slow_tick_w)
  );

  assign tick_w = ctrl_w[CTRL_SLOW] ? slow_tick_w : 1'b1;

  wdt_core #(.CNT_W(CNT_W), .RST_PULSE_LEN(RST_PULSE_LEN)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_w),
    .en_i      (ctrl_w[CTRL_EN]),
    .rst_en_i  (ctrl_w[CTRL_RST]),
    .tick_i    (tick_w),
    .reload_i  (reload_w),
    .cnt_o     (cnt_w),
    .running_o (running_w),
    .timeout_o (timeout_o),
    .sys_rst_o (sys_rst_o)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_we_i,
  input logic [3:0]       bus_addr_i,
  input logic [31:0]      bus_wdata_i,
  input logic             timeout_o,
  input logic             sys_rst_o,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] reload_w,
  input logic [31:0]      ctrl_w,
  input logic             load_w
);
  AST_TIMEOUT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R5

  AST_TIMEOUT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(ctrl_w[0])); // R5

  AST_RST_WITH_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> (timeout_o && $past(ctrl_w[1]))); // R6

  AST_KEY_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i[3:2] == 2'd2 && bus_wdata_i == 32'h4755)
      |=> (cnt_w == $past(reload_w))); // R4

  AST_FAST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_w[0] && !ctrl_w[4] && !load_w && cnt_w != '0)
      |=> (cnt_w == $past(cnt_w) - 1'b1)); // R3

  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_w[0] && !load_w) |=> $stable(cnt_w)); // R8
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .timeout_o   (timeout_o),
  .sys_rst_o   (sys_rst_o),
  .cnt_w       (cnt_w),
  .reload_w    (reload_w),
  .ctrl_w      (ctrl_w),
  .load_w      (load_w)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int DIV = 4;
  localparam int PLEN = 3;
  localparam int SIG_RD = 0, SIG_TO = 1, SIG_RST = 2;

  typedef struct {
    int          cyc;
    int          sig;
    logic [31:0] val;
    string       req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        timeout_o, sys_rst_o;

  int   cyc = 0;
  int   n_vec = 0;
  int   n_err = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  logic [31:0] act;

  keyed_wdt #(.CNT_W(32), .PRESCALE_DIV(DIV), .RST_PULSE_LEN(PLEN)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .timeout_o(timeout_o), .sys_rst_o(sys_rst_o)
  );

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare every expectation stamped with the current cycle
  always @(negedge clk_i) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].cyc == cyc) begin
        case (exp_q[i].sig)
          SIG_RD:  act = bus_rdata_o;
          SIG_TO:  act = {31'b0, timeout_o};
          default: act = {31'b0, sys_rst_o};
        endcase
        n_vec++;
        if (act !== exp_q[i].val) begin
          n_err++;
          $display("FAIL %s cyc=%0d sig=%0d actual=%h expected=%h",
                   exp_q[i].req, cyc, exp_q[i].sig, act, exp_q[i].val);
        end
        exp_q.delete(i);
      end
    end
  end

  task automatic expect_at(int c, int s, logic [31:0] v, string r);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] v, string r);
    bus_we_i = 1'b0;
    bus_addr_i = a;
    expect_at(cyc, SIG_RD, v, r);
    @(posedge clk_i); #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i); #1;
    bus_we_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired, run hung");
    finish_run();
  end

  initial begin
    int c0, c1, c2, c3, c4;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    expect_at(cyc, SIG_TO, 0, "R1");
    expect_at(cyc, SIG_RST, 0, "R1");
    rd(4'h0, 0, "R1");
    rd(4'h4, 0, "R1");
    rd(4'hC, 0, "R1");
    rd(4'h8, 0, "R9");

    // R2 reload storage
    wr(4'h4, 10);
    rd(4'h4, 10, "R2");

    // R3 enable edge loads, counts per clock
    wr(4'hC, 32'h3);
    c0 = cyc;
    rd(4'h0, 10, "R3");
    rd(4'h0, 9, "R3");
    rd(4'h0, 8, "R3");
    rd(4'h0, 7, "R3");
    wr(4'h8, 32'h4756);        // wrong key
    rd(4'h0, 5, "R4");
    wr(4'h8, 32'h4755);        // key
    c1 = cyc;
    if (c1 != c0 + 7) $display("note: schedule offset %0d", c1 - c0);
    for (int k = 0; k <= 10; k++) expect_at(c1 + k, SIG_TO, 0, "R5");
    expect_at(c1 + 11, SIG_TO, 1, "R5");
    expect_at(c1 + 12, SIG_TO, 0, "R5");
    expect_at(c1 + 10, SIG_RST, 0, "R6");
    for (int k = 11; k < 11 + PLEN; k++) expect_at(c1 + k, SIG_RST, 1, "R6");
    expect_at(c1 + 11 + PLEN, SIG_RST, 0, "R6");
    rd(4'h0, 10, "R4");
    idle(14);
    rd(4'h0, 0, "R6");

    // R6 restart after halt, then R8 disable
    wr(4'h8, 32'h4755);
    c2 = cyc;
    rd(4'h0, 10, "R6");
    wr(4'hC, 32'h0);
    c3 = cyc;
    if (c3 != c2 + 2) $display("note: schedule offset %0d", c3 - c2);
    for (int k = 0; k < 20; k++) begin
      expect_at(c3 + k, SIG_TO, 0, "R8");
      expect_at(c3 + k, SIG_RST, 0, "R8");
    end
    idle(5);
    wr(4'h0, 32'hABCD);
    rd(4'h0, 8, "R9");
    rd(4'h8, 0, "R9");
    idle(10);
    rd(4'h0, 8, "R8");

    // R7 prescaled count, R5 reload without reset, R10 spare bits
    wr(4'h4, 2);
    wr(4'hC, 32'hC000_0011);
    c4 = cyc;
    expect_at(c4 + 11, SIG_TO, 0, "R7");
    expect_at(c4 + 12, SIG_TO, 1, "R7");
    expect_at(c4 + 13, SIG_TO, 0, "R5");
    expect_at(c4 + 12, SIG_RST, 0, "R5");
    expect_at(c4 + 13, SIG_RST, 0, "R5");
    idle(3);
    rd(4'h0, 2, "R7");
    rd(4'h0, 1, "R7");
    idle(7);
    rd(4'h0, 2, "R5");
    idle(3);
    rd(4'h0, 1, "R10");
    rd(4'hC, 32'hC000_0011, "R10");

    idle(4);
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL unchecked expectations actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule